// File: doc/BRIEF.md
# Multi-Mode Up-Counting Timer

This block is an up-counter with three behaviours selected by a two-bit mode field. Its width is a parameter and defaults to 8 bits. In interval mode it counts up to a compare value, then restarts from zero, pulses an event interrupt and flips a square-wave pin. In PWM mode it runs freely around its full range and drives a pulse-width output whose high time follows the compare value. In capture mode a rising edge on an asynchronous event pin copies the running count into the data register and restarts the count. Overflow pulses let software extend the measured interval past one counter range.

Software writes a data register, plus a control word that holds the mode and a run bit. An external single-cycle tick enables counting and stands for the selected timer clock. The compare logic never uses the data register directly. It uses a shadow copy that is refreshed only when counting starts, when the mode changes, or when the current period ends. A write made in the middle of a period therefore takes effect at a clean boundary. The data register and the live count are readable on output ports.

Top module: `tmr8_multimode`

## Requirements
- R1: After reset the count, the data register and the compare copy are zero, the mode is interval (code 00), the run bit is clear, and the toggle pin, PWM pin and both interrupt outputs are low.
- R2: In interval mode (code 00), a tick while the count equals the compare copy sets the count to zero, raises `irq_evt` for the next cycle and inverts `tgl_out`, so events come every compare+1 ticks. Otherwise a tick adds one to the count.
- R3: In PWM mode (code 01), a compare hit does not clear the count. The count wraps from all-ones to zero and `irq_ovf` pulses for each wrap. `irq_evt` pulses on the tick where the count equals the compare copy.
- R4: In PWM mode `pwm_out` is high exactly while the count is less than or equal to the compare copy. This gives compare+1 high ticks per 256, and a compare of FFh keeps the pin high. In other modes `pwm_out` is low.
- R5: In capture mode (code 10), with the run bit set, a rising edge of `cap_in` takes effect three clock edges after it is first sampled. On that edge the data register takes the count held just before the edge, the count becomes zero, and `irq_evt` pulses.
- R6: In capture mode the count wraps and pulses `irq_ovf` as in R3. Elapsed ticks from the restart to the capture edge equal 256 × (overflow pulses before the capture pulse) + captured value.
- R7: When a capture and a wrap fall on the same edge, the count becomes zero, the data register receives FFh, and `irq_evt` and `irq_ovf` both pulse in that cycle.
- R8: The compare copy is loaded from the data register only on a start (run bit written 0 to 1), on a mode change, on an interval match, or on a wrap. A data write at any other time has no effect on the outputs until the next such event.
- R9: The count changes only on a tick while the run bit is set, or on a clear. Clearing the run bit, or holding `tick` low, freezes the count.
- R10: A control write that changes the mode clears the count and reloads the compare copy on that edge, whether or not the run bit is set.
- R11: One capture happens per rising edge of `cap_in`, however long the pin stays high. Each interrupt event is a pulse that lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | Write strobe for the data register |
| data_in | input | CNT_W | Value for the data register |
| ctrl_wr | input | 1 | Write strobe for mode and run bit |
| mode_in | input | 2 | Mode: 00 interval, 01 PWM, 10 capture |
| run_in | input | 1 | Run bit |
| tick | input | 1 | Count-enable tick |
| cap_in | input | 1 | Asynchronous capture event |
| data_out | output | CNT_W | Data register (holds captured value) |
| count_out | output | CNT_W | Live count |
| tgl_out | output | 1 | Interval-mode toggle pin |
| pwm_out | output | 1 | PWM pin |
| irq_evt | output | 1 | Match/capture interrupt pulse |
| irq_ovf | output | 1 | Overflow interrupt pulse |

## Verification
Each control or data write acts on the clock edge that follows it. Counts, compare-driven outputs and interrupt pulses appear one edge after the tick that causes them. A capture needs three edges from the moment `cap_in` rises, because of the two synchronizer flops and the edge register. The bench drives inputs and samples outputs on the falling edge. It computes each expected count, pin level and pulse from the number of edges since the restart edge, using the arithmetic above. Pulse checks are made every cycle, so a pulse that arrives one cycle early or late fails.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
   typedef enum logic [1:0] {
      TM_INTERVAL = 2'b00,
      TM_PWM      = 2'b01,
      TM_CAPTURE  = 2'b10,
      TM_RSVD     = 2'b11
   } tm_mode_e;
endpackage

// File: rtl/tmr8_edge_sync.sv
module tmr8_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tmr8_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh_q[0] <= 1'b0;
            else        sh_q[0] <= async_in;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sh_q[STAGES-1];

   assign rise_o = sh_q[STAGES-1] & ~last_q;

   AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o); // R11
endmodule

// File: rtl/tmr8_cmp_buf.sv
module tmr8_cmp_buf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_val,
   input  logic         cap_en,
   input  logic [W-1:0] cap_val,
   input  logic         reload,
   output logic [W-1:0] data_q,
   output logic [W-1:0] cmp_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         cmp_q  <= '0;
      end else begin
         if (cap_en)     data_q <= cap_val;
         else if (wr_en) data_q <= wr_val;
         if (reload)     cmp_q  <= data_q;
      end
   end

   AST_CMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(cmp_q)); // R8
   AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> data_q == $past(cap_val)); // R5
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
   import tmr8_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_wr,
   input  logic [1:0]   mode_in,
   input  logic         run_in,
   input  logic         tick,
   input  logic         cap_rise,
   input  logic [W-1:0] cmp,
   output logic [W-1:0] cnt_q,
   output logic         cap_take,
   output logic         reload,
   output logic         tgl_o,
   output logic         pwm_o,
   output logic         irq_evt_o,
   output logic         irq_ovf_o
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] MAXV = '1;

   tm_mode_e mode_q;
   logic     run_q;
   logic     mode_chg, start, adv, hit, at_max;
   logic     int_match, pwm_match, wrap, counting;

   always_comb begin
      mode_chg  = ctrl_wr && (tm_mode_e'(mode_in) != mode_q);
      start     = ctrl_wr && run_in && !run_q;
      adv       = run_q && tick && !mode_chg;
      hit       = (cnt_q == cmp);
      at_max    = (cnt_q == MAXV);
      counting  = (mode_q != TM_RSVD);
      cap_take  = run_q && (mode_q == TM_CAPTURE) && cap_rise && !mode_chg;
      int_match = adv && (mode_q == TM_INTERVAL) && hit;
      pwm_match = adv && (mode_q == TM_PWM) && hit;
      wrap      = adv && ((mode_q == TM_PWM) || (mode_q == TM_CAPTURE)) && at_max;
      reload    = start || mode_chg || int_match || wrap;
      pwm_o     = (mode_q == TM_PWM) && (cnt_q <= cmp);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= TM_INTERVAL;
         run_q  <= 1'b0;
      end else if (ctrl_wr) begin
         mode_q <= tm_mode_e'(mode_in);
         run_q  <= run_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (mode_chg)            cnt_q <= '0;
      else if (cap_take)            cnt_q <= '0;
      else if (int_match)           cnt_q <= '0;
      else if (adv && counting)     cnt_q <= cnt_q + ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgl_o     <= 1'b0;
         irq_evt_o <= 1'b0;
         irq_ovf_o <= 1'b0;
      end else begin
         irq_evt_o <= int_match || pwm_match || cap_take;
         irq_ovf_o <= wrap;
         if (int_match) tgl_o <= ~tgl_o;
      end
   end

   AST_INT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      int_match |=> (cnt_q == '0) && irq_evt_o); // R2
   AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !cap_take) |=> (cnt_q == '0) && irq_ovf_o); // R3
   AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      cap_take |=> (cnt_q == '0) && irq_evt_o); // R5
   AST_BOTH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_take && wrap) |=> irq_evt_o && irq_ovf_o); // R7
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_chg && !cap_take && !adv) |=> $stable(cnt_q)); // R9
   AST_MODE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (cnt_q == '0)); // R10
endmodule

// File: rtl/tmr8_multimode.sv
module tmr8_multimode #(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             data_wr,
   input  logic [CNT_W-1:0] data_in,
   input  logic             ctrl_wr,
   input  logic [1:0]       mode_in,
   input  logic             run_in,
   input  logic             tick,
   input  logic             cap_in,
   output logic [CNT_W-1:0] data_out,
   output logic [CNT_W-1:0] count_out,
   output logic             tgl_out,
   output logic             pwm_out,
   output logic             irq_evt,
   output logic             irq_ovf
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("tmr8_multimode: CNT_W must lie in 2..32");
   end

   logic             cap_rise, cap_take, reload;
   logic [CNT_W-1:0] cmp, cnt;

   tmr8_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(cap_in), .rise_o(cap_rise)
   );

   tmr8_cmp_buf #(.W(CNT_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(data_wr), .wr_val(data_in),
      .cap_en(cap_take), .cap_val(cnt),
      .reload(reload), .data_q(data_out), .cmp_q(cmp)
   );

   tmr8_core #(.W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(ctrl_wr), .mode_in(mode_in), .run_in(run_in),
      .tick(tick), .cap_rise(cap_rise), .cmp(cmp),
      .cnt_q(cnt), .cap_take(cap_take), .reload(reload),
      .tgl_o(tgl_out), .pwm_o(pwm_out),
      .irq_evt_o(irq_evt), .irq_ovf_o(irq_ovf)
   );

   assign count_out = cnt;
endmodule

// File: tb/tb_tmr8_multimode.sv
module tb_tmr8_multimode;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       data_wr = 1'b0;
   logic [7:0] data_in = '0;
   logic       ctrl_wr = 1'b0;
   logic [1:0] mode_in = '0;
   logic       run_in = 1'b0;
   logic       tick = 1'b1;
   logic       cap_in = 1'b0;
   logic [7:0] data_out, count_out;
   logic       tgl_out, pwm_out, irq_evt, irq_ovf;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tmr8_multimode dut (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
      .ctrl_wr(ctrl_wr), .mode_in(mode_in), .run_in(run_in), .tick(tick),
      .cap_in(cap_in), .data_out(data_out), .count_out(count_out),
      .tgl_out(tgl_out), .pwm_out(pwm_out), .irq_evt(irq_evt), .irq_ovf(irq_ovf)
   );

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr_data(input int v);
      data_wr = 1'b1; data_in = 8'(v);
      step();
      data_wr = 1'b0;
   endtask

   task automatic wr_ctrl(input int m, input bit r);
      ctrl_wr = 1'b1; mode_in = 2'(m); run_in = r;
      step();
      ctrl_wr = 1'b0;
   endtask

   task automatic restart(input int m);
      wr_ctrl((m == 0) ? 1 : 0, 1'b0);
      wr_ctrl(m, 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      int ovf, tg0, el;
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1 count", count_out, 0);
      check("R1 data", data_out, 0);
      check("R1 tgl", tgl_out, 0);
      check("R1 pwm", pwm_out, 0);
      check("R1 irq_evt", irq_evt, 0);
      check("R1 irq_ovf", irq_ovf, 0);

      // R2 interval sweep
      for (int v = 0; v < 256; v += 17) begin
         wr_data(v);
         restart(0);
         tg0 = tgl_out;
         for (int n = 1; n <= 2 * (v + 1); n++) begin
            step();
            check("R2 count", count_out, n % (v + 1));
            check("R2 irq_evt", irq_evt, int'(n % (v + 1) == 0));
            check("R2 tgl", tgl_out, tg0 ^ ((n / (v + 1)) & 1));
         end
      end

      // R3 R4 PWM sweep
      for (int v = 0; v < 256; v += 17) begin
         wr_data(v);
         restart(1);
         for (int n = 0; n <= 300; n++) begin
            if (n > 0) step();
            check("R3 count", count_out, n % 256);
            check("R3 irq_ovf", irq_ovf, int'(n > 0 && n % 256 == 0));
            check("R3 irq_evt", irq_evt, int'(n > 0 && (n - 1) % 256 == v));
            check("R4 pwm", pwm_out, int'(n % 256 <= v));
         end
      end

      // R8 PWM: mid-period write waits for the wrap
      wr_data(10);
      restart(1);
      for (int n = 1; n <= 406; n++) begin
         data_wr = (n == 51); data_in = 8'd200;
         step();
         if (n == 150) check("R8 pwm old compare", pwm_out, 0);
         if (n == 406) check("R8 pwm new compare", pwm_out, 1);
      end
      data_wr = 1'b0;

      // R8 interval: mid-period write waits for the match
      wr_data(20);
      restart(0);
      for (int n = 1; n <= 40; n++) begin
         data_wr = (n == 4); data_in = 8'd5;
         step();
         check("R8 interval period", irq_evt, int'(n == 21 || n == 27 || n == 33 || n == 39));
      end
      data_wr = 1'b0;

      // R10 mode change clears and reloads
      wr_data(200);
      restart(1);
      repeat (50) step();
      wr_data(3);
      check("R10 pwm uses old compare", pwm_out, 1);
      wr_ctrl(0, 1'b1);
      check("R10 count cleared", count_out, 0);
      for (int n = 1; n <= 4; n++) begin
         step();
         check("R10 reloaded compare", irq_evt, int'(n == 4));
      end

      // R9 run bit and tick gating
      restart(2);
      repeat (10) step();
      wr_ctrl(2, 1'b0);
      check("R9 last advance", count_out, 11);
      for (int n = 0; n < 8; n++) begin
         step();
         check("R9 held by run", count_out, 11);
      end
      wr_ctrl(2, 1'b1);
      check("R9 start no advance", count_out, 11);
      tick = 1'b0;
      for (int n = 0; n < 5; n++) begin
         step();
         check("R9 held by tick", count_out, 11);
      end
      tick = 1'b1;
      step();
      check("R9 resumes", count_out, 12);

      // R5 R6 R7 R11 capture
      foreach (el_list[i]) begin
         restart(2);
         ovf = 0;
         for (int n = 0; n < el_list[i]; n++) begin
            step();
            ovf += int'(irq_ovf);
         end
         cap_in = 1'b1;
         step(); ovf += int'(irq_ovf);
         step(); ovf += int'(irq_ovf);
         check("R5 no early capture", irq_evt, 0);
         step();
         el = el_list[i] + 2;
         check("R5 captured value", data_out, el % 256);
         check("R5 count cleared", count_out, 0);
         check("R5 irq_evt", irq_evt, 1);
         check("R6 elapsed", 256 * ovf + int'(data_out), el);
         if (el % 256 == 255) check("R7 both irqs", irq_ovf, 1);
         for (int n = 1; n <= 4; n++) begin
            step();
            check("R11 single pulse", irq_evt, 0);
            check("R11 keeps counting", count_out, n);
         end
         cap_in = 1'b0;
         repeat (4) step();
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   int el_list [4] = '{5, 300, 600, 253};
endmodule